// File: doc/BRIEF.md
# Pseudo-Random Noise Bit Generator

This block produces one pseudo-random noise bit that several tone channels can share. A free-running prescaler divides the system clock by eight and gives one enable pulse per eight clocks. A 5-bit period value, loaded through a single write strobe and data bus, sets how many enable pulses pass between steps of a 17-bit shift register. Each time the period count expires, the shift register advances by one step and the noise bit may invert.

The noise bit does not copy a register bit. It inverts on an expiry only when the two lowest register bits differ. The value they hold just before the shift decides this. The whole register is also driven out unchanged, so the sequence can be observed.

Top module: `noise_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `lfsr_state` reads 17'h00001 and `noise_out` reads 1.
- R2: A write keeps only `wr_data[4:0]` as the period. The upper data bits have no effect on the step spacing, so a write of 8'hE3 steps the register every 24 clocks.
- R3: A stored period of 0 steps the register every enable, exactly as a period of 1 does (every 8 clocks).
- R4: With period N (1 to 31) held steady, the register steps exactly once every 8*N clocks. Steps happen only on enable cycles, and enables never come on two adjacent clocks.
- R5: One step is in Galois form. If bit 0 is 1, the register is XORed with 18'h24000, then it shifts right by one, so the old bit 0 enters at bit 16. Between steps, `lfsr_state` and `noise_out` hold their values.
- R6: On a step, `noise_out` inverts if and only if bit 0 and bit 1 of `lfsr_state` differ before that step.
- R7: A write does not clear the period counter. If the new period is at or below the enables already counted plus one, the step occurs at the very next enable.
- R8: A write presented in the same cycle as an enable takes effect from the following enable. The coinciding enable is judged against the previous period.
- R9: At period 1, the first 64 inversions of `noise_out`, and the register value at each one, match an independent model of the 17-bit sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Period write strobe, one cycle |
| wr_data | input | 8 | Write data; low 5 bits form the period |
| noise_out | output | 1 | Shared noise bit |
| lfsr_state | output | 17 | Current shift register contents |

## Verification
A period write and a prescaler enable can land on the same clock edge. A period write can also arrive while the counter already holds more enables than the new period. The bench aligns its own prescaler model so that a write strobe sits exactly on an enable cycle. It then judges that this enable still steps under the old period of 1 and that the next step comes only after the new period. It also writes a short period into a counter that is half way through a long one, and judges that the step arrives at the very next enable, seven clocks later.

// File: rtl/noise_pkg.sv
package noise_pkg;

    localparam int LFSR_W = 17;
    localparam logic [LFSR_W-1:0] LFSR_SEED   = LFSR_W'(1);
    localparam logic [LFSR_W:0]   GALOIS_MASK = 18'h24000;

    typedef struct packed {
        logic [LFSR_W-1:0] state;
        logic              bit_out;
    } noise_state_t;

    // One Galois step of the register plus the conditional output inversion.
    function automatic noise_state_t noise_advance(noise_state_t cur);
        logic [LFSR_W:0] wide;
        noise_state_t    nxt;
        wide = {1'b0, cur.state};
        if (cur.state[0]) begin
            wide = wide ^ GALOIS_MASK;
        end
        nxt.state   = wide[LFSR_W:1];
        nxt.bit_out = cur.bit_out ^ (cur.state[0] ^ cur.state[1]);
        return nxt;
    endfunction

    function automatic noise_state_t noise_reset_value();
        noise_state_t r;
        r.state   = LFSR_SEED;
        r.bit_out = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/noise_prescale.sv
module noise_prescale #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic ce
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;

    assign ce = (div_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
        end else if (ce) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/noise_period_reg.sv
module noise_period_reg #(
    parameter int DATA_W = 8,
    parameter int PER_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PER_W-1:0]  per_eff
);
    logic [PER_W-1:0] per_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= '0;
        end else if (wr_en) begin
            per_q <= wr_data[PER_W-1:0];
        end
    end

    // A zero period is treated as one.
    assign per_eff = (per_q == '0) ? PER_W'(1) : per_q;
endmodule

// File: rtl/noise_period_cnt.sv
module noise_period_cnt #(
    parameter int PER_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [PER_W-1:0] per_eff,
    output logic             fire
);
    logic [PER_W-1:0] cnt;
    logic [PER_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + (PER_W+1)'(1);
    assign fire    = ce && (cnt_inc >= {1'b0, per_eff});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ce) begin
            cnt <= fire ? '0 : cnt_inc[PER_W-1:0];
        end
    end
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
    import noise_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [LFSR_W-1:0] state_o,
    output logic              bit_o
);
    noise_state_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= noise_reset_value();
        end else if (step) begin
            cur <= noise_advance(cur);
        end
    end

    assign state_o = cur.state;
    assign bit_o   = cur.bit_out;
endmodule

// File: rtl/noise_gen.sv
module noise_gen
    import noise_pkg::*;
#(
    parameter int DIV    = 8,
    parameter int DATA_W = 8,
    parameter int PER_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              noise_out,
    output logic [LFSR_W-1:0] lfsr_state
);
    logic             ce_w;
    logic             fire_w;
    logic [PER_W-1:0] per_w;

    noise_prescale #(.DIV(DIV)) u_pre (
        .clk (clk),
        .rst (rst),
        .ce  (ce_w)
    );

    noise_period_reg #(.DATA_W(DATA_W), .PER_W(PER_W)) u_per (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .per_eff (per_w)
    );

    noise_period_cnt #(.PER_W(PER_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce_w),
        .per_eff (per_w),
        .fire    (fire_w)
    );

    noise_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .step    (fire_w),
        .state_o (lfsr_state),
        .bit_o   (noise_out)
    );
endmodule

// File: rtl/noise_gen_chk.sv
module noise_gen_chk
    import noise_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce,
    input logic              fire,
    input logic              noise_out,
    input logic [LFSR_W-1:0] lfsr_state
);
    AST_RESET_SEED: assert property (@(posedge clk)
        rst |=> (lfsr_state == LFSR_SEED) && noise_out); // R1

    AST_STEP_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
        fire |-> ce); // R4

    AST_ENABLE_SPACED: assert property (@(posedge clk) disable iff (rst)
        ce |=> !ce); // R4

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(lfsr_state) && $stable(noise_out)); // R5

    AST_SHIFT_IN_TOP: assert property (@(posedge clk) disable iff (rst)
        fire |=> lfsr_state[LFSR_W-1] == $past(lfsr_state[0])); // R5

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '0); // R5

    AST_TOGGLE_RULE: assert property (@(posedge clk) disable iff (rst)
        fire |=> (noise_out != $past(noise_out)) ==
                 ($past(lfsr_state[0]) != $past(lfsr_state[1]))); // R6
endmodule

bind noise_gen noise_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce         (ce_w),
    .fire       (fire_w),
    .noise_out  (noise_out),
    .lfsr_state (lfsr_state)
);

// File: tb/tb_noise_gen.sv
`timescale 1ns/1ps
module tb_noise_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        noise_out;
    logic [16:0] lfsr_state;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // independent model state
    int m_pre = 0;
    int m_cnt = 0;
    int m_per = 0;
    int m_lfsr = 1;
    int m_out = 1;

    always #4 clk = ~clk;

    noise_gen dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .noise_out  (noise_out),
        .lfsr_state (lfsr_state)
    );

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: advance model from pre-edge inputs, then compare
    task automatic tick();
        bit ce;
        bit fire;
        int eff;
        ce   = (m_pre == 7);
        eff  = (m_per == 0) ? 1 : m_per;
        fire = ce && (m_cnt + 1 >= eff);
        @(posedge clk);
        #2;
        cycles++;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_per = 0; m_lfsr = 1; m_out = 1;
        end else begin
            m_pre = (m_pre + 1) % 8;
            if (ce) m_cnt = fire ? 0 : m_cnt + 1;
            if (fire) begin
                if (((m_lfsr + 1) & 2) != 0) m_out = 1 - m_out;
                if ((m_lfsr & 1) != 0) m_lfsr = m_lfsr ^ 32'h24000;
                m_lfsr = m_lfsr >> 1;
            end
            if (wr_en) m_per = wr_data & 31;
        end
        check(int'(lfsr_state) == m_lfsr, "R5 state", int'(lfsr_state), m_lfsr);
        check(int'(noise_out) == m_out, "R6 noise", int'(noise_out), m_out);
    endtask

    task automatic write_per(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic wait_change(output int n);
        logic [16:0] prev;
        prev = lfsr_state;
        n = 0;
        do begin
            tick();
            n++;
        end while (lfsr_state == prev && n < 4000);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        check(lfsr_state == 17'h1, "R1 seed", int'(lfsr_state), 1);
        check(noise_out == 1'b1, "R1 noise", int'(noise_out), 1);
        rst = 1'b0;
        check(lfsr_state == 17'h1, "R1 seed after release", int'(lfsr_state), 1);
    endtask

    task automatic t_interval(input logic [7:0] d, input int exp, input string tag);
        int n;
        write_per(d);
        wait_change(n);
        wait_change(n);
        check(n == exp, tag, n, exp);
        wait_change(n);
        check(n == exp, tag, n, exp);
    endtask

    task automatic t_midway_write();
        int n;
        write_per(8'd20);
        wait_change(n);
        while (!(m_cnt == 10 && m_pre == 0)) tick();
        write_per(8'd4);
        wait_change(n);
        check(n == 7, "R7 no counter clear", n, 7);
    endtask

    task automatic t_write_on_enable();
        int n;
        logic [16:0] prev;
        write_per(8'd1);
        wait_change(n);
        while (m_pre != 7) tick();
        prev = lfsr_state;
        write_per(8'd31);
        check(lfsr_state != prev, "R8 old period at coinciding enable",
              int'(lfsr_state), int'(prev));
        wait_change(n);
        check(n == 248, "R8 new period from next enable", n, 248);
    endtask

    task automatic t_sequence64();
        int n;
        int toggles = 0;
        int bad = 0;
        int last;
        write_per(8'd1);
        wait_change(n);
        last = m_out;
        while (toggles < 64 && cycles < 150000) begin
            tick();
            if (m_out != last) begin
                toggles++;
                last = m_out;
                if (int'(noise_out) != m_out || int'(lfsr_state) != m_lfsr) bad++;
            end
        end
        check(toggles == 64, "R9 toggle count", toggles, 64);
        check(bad == 0, "R9 toggle sequence", bad, 0);
    endtask

    initial begin
        t_reset();
        t_interval(8'd5,   40,  "R4 period 5");
        t_interval(8'd31,  248, "R4 period 31");
        t_interval(8'h00,  8,   "R3 period zero");
        t_interval(8'hE3,  24,  "R2 upper bits ignored");
        t_midway_write();
        t_write_on_enable();
        t_sequence64();
        report();
        $finish;
    end

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        report();
        $finish;
    end
endmodule